// File: doc/BRIEF.md
# Single-Pin Serial ADC Conversion Master

This block runs one conversion on a serial analog-to-digital converter whose data input and data output share one wire. When the host pulses `start_i` while the block is idle, the master pulls chip select low and generates a serial clock from the system clock. It sends a four-bit command that picks the input channel and the input mode. It then stops driving the shared wire and clocks in a ten-bit result, most significant bit first. At the end it raises chip select again and presents the result as two bytes aligned to the top: a high byte and a low byte that is padded with zeros.

The data pad is split into three signals: `sdata_o`, `sdata_oe_o` and `sdata_i`. The pad cell or board logic joins them onto the single wire. The serial clock runs at `1/(2*DIV_HALF)` of the system clock and rests low between transactions. A transaction takes 27 serial half-periods: eight for the command and nineteen for the result.

Top module: `adc3w_master`

## Requirements
- R1: After reset, and whenever the block is idle, `cs_n_o` is 1, `sclk_o` is 0, `sdata_oe_o` is 0, `busy_o` and `done_o` are 0. Both result bytes reset to 0.
- R2: A `start_i` pulse is taken only when `busy_o` is 0. `busy_o` rises on the next clock and stays high for exactly 27*DIV_HALF cycles. It falls in the same cycle that `done_o` goes high for a single cycle. A `start_i` pulse while busy is ignored: it does not change the command, the timing, or the number of chip-select frames.
- R3: Every serial clock half-period lasts DIV_HALF system cycles. The clock starts low and has exactly 13 rising edges per transaction.
- R4: The command goes out MSB first as 1, `sgl_i`, `odd_i`, 0. Here `sgl_i`=1 selects single-ended input and `odd_i` selects the odd channel or the sign. Each bit is put on `sdata_o` while `sclk_o` is low and does not change while `sclk_o` is high.
- R5: `sdata_oe_o` falls one system cycle after the 4th rising serial edge. This is before the 4th falling edge. It stays 0 for the rest of the transaction, so the master and the converter never drive the wire at the same time.
- R6: The converter's result starts at the 4th falling edge. The master samples `sdata_i` in the last system cycle of each of the ten low half-periods that follow, and takes B9 first.
- R7: When `done_o` is high, `hi_o` equals B9..B2 and `lo_o` equals {B1, B0, 000000}. Both bytes hold until the next `done_o`.
- R8: `cs_n_o` goes low in the cycle `busy_o` rises. It returns high in the cycle `done_o` rises, with `sclk_o` low.
- R9: Asserting `rst_n` low during a transaction returns the block to idle at once, with `cs_n_o` high, `sclk_o` low and the data wire released. A later transaction then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| sgl_i | input | 1 | 1 = single-ended, 0 = differential |
| odd_i | input | 1 | Odd channel / sign select |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when result bytes are valid |
| hi_o | output | 8 | Result bits B9..B2 |
| lo_o | output | 8 | B1, B0, then six zeros |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Value driven onto the shared data wire |
| sdata_oe_o | output | 1 | Drive enable for the shared data wire |
| sdata_i | input | 1 | Value read from the shared data wire |

## Verification
A wrong half-period index inside the sequencer shows up at the pins within one serial half-period. The 13-edge count, the 27*DIV_HALF busy length or the hand-over edge shifts, and the converter model sees the wrong command bit or a collision on the wire. A fault in the drive enable shows up at once as both sides driving the wire in the same half-period. A slip in the shift register or in the packing only appears at `done_o`, as wrong or misaligned result bytes. The bench therefore checks both byte values for every transaction, including all-ones, all-zeros and single-bit patterns.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;

    localparam int CMD_BITS  = 4;
    localparam int RES_BITS  = 10;
    localparam int BYTE_W    = 8;
    localparam int HALVES    = 2 * (CMD_BITS + RES_BITS) - 1;
    localparam int LAST_HALF = HALVES - 1;
    localparam int RES_HALF0 = 2 * CMD_BITS;
    localparam int HALF_W    = $clog2(HALVES);
    localparam int PAD_W     = 2 * BYTE_W - RES_BITS;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e             mode;
        logic [HALF_W-1:0]     half;
        logic [CMD_BITS-1:0]   cmd;
        logic                  cs_n;
        logic                  sclk;
        logic                  sd;
        logic                  oe;
        logic                  busy;
        logic                  done;
    } seq_state_t;

    typedef struct packed {
        logic [RES_BITS-1:0]   sh;
        logic [BYTE_W-1:0]     hi;
        logic [BYTE_W-1:0]     lo;
    } pack_state_t;

endpackage

// File: rtl/adc3w_halfdiv.sv
module adc3w_halfdiv #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == CNT_LAST);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: half-period counter never passes its last value
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R3: counter restarts from zero whenever the sequencer is idle
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/adc3w_seq.sv
module adc3w_seq
    import adc3w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sgl,
    input  logic odd,
    input  logic tick,
    output logic cs_n,
    output logic sclk,
    output logic sd,
    output logic oe,
    output logic busy,
    output logic done,
    output logic shift_en,
    output logic capture
);

    localparam logic [HALF_W-1:0] H_LAST    = HALF_W'(LAST_HALF);
    localparam logic [HALF_W-1:0] H_RES0    = HALF_W'(RES_HALF0);
    localparam logic [HALF_W-1:0] H_TURN    = HALF_W'(RES_HALF0 - 1);

    localparam seq_state_t IDLE_STATE = '{
        mode: SEQ_IDLE, half: '0, cmd: '0, cs_n: 1'b1, sclk: 1'b0,
        sd: 1'b0, oe: 1'b0, busy: 1'b0, done: 1'b0
    };

    seq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shift_en = 1'b0;
        capture  = 1'b0;
        case (s_q.mode)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.mode = SEQ_RUN;
                    s_d.half = '0;
                    s_d.cmd  = {1'b1, sgl, odd, 1'b0};
                    s_d.cs_n = 1'b0;
                    s_d.sclk = 1'b0;
                    s_d.sd   = 1'b1;
                    s_d.oe   = 1'b1;
                    s_d.busy = 1'b1;
                end
            end
            SEQ_RUN: begin
                // release the wire one cycle after the last command rise
                if (s_q.oe && s_q.sclk && (s_q.half == H_TURN)) begin
                    s_d.oe = 1'b0;
                end
                if (tick) begin
                    if (!s_q.half[0] && (s_q.half >= H_RES0)) begin
                        shift_en = 1'b1;
                    end
                    if (s_q.half == H_LAST) begin
                        capture  = 1'b1;
                        s_d      = IDLE_STATE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.half = s_q.half + 1'b1;
                        s_d.sclk = ~s_q.sclk;
                        if (s_q.half[0] && (s_q.half < H_TURN)) begin
                            s_d.cmd = s_q.cmd << 1;
                            s_d.sd  = s_q.cmd[CMD_BITS-2];
                        end
                    end
                end
            end
            default: s_d = IDLE_STATE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= IDLE_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n = s_q.cs_n;
    assign sclk = s_q.sclk;
    assign sd   = s_q.sd;
    assign oe   = s_q.oe;
    assign busy = s_q.busy;
    assign done = s_q.done;

    // R1: idle pins
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> (s_q.cs_n && !s_q.sclk && !s_q.oe));

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R2: busy ends only together with done
    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.done);

    // R4: command bit does not move while the clock is high
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe && s_q.sclk) |-> $stable(s_q.sd));

    // R5: wire released for the whole result phase
    p_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && (s_q.half >= H_RES0)) |-> !s_q.oe);

    // R8: chip select low for the whole frame, rises with done
    p_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> !s_q.cs_n);
    p_cs_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cs_n) |-> (s_q.done && !s_q.sclk));

endmodule

// File: rtl/adc3w_packer.sv
module adc3w_packer
    import adc3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              capture,
    input  logic              sdi,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);

    pack_state_t p_d, p_q;
    logic [RES_BITS-1:0] word;

    always_comb begin
        p_d  = p_q;
        word = p_q.sh;
        if (shift_en) begin
            word = {p_q.sh[RES_BITS-2:0], sdi};
        end
        p_d.sh = word;
        if (capture) begin
            p_d.hi = word[RES_BITS-1 -: BYTE_W];
            p_d.lo = {word[RES_BITS-BYTE_W-1:0], {PAD_W{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign hi = p_q.hi;
    assign lo = p_q.lo;

    // R7: result bytes hold between captures
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(p_q.hi) && $stable(p_q.lo)));

    // R7: padding bits of the low byte stay zero
    p_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.lo[PAD_W-1:0] == '0);

endmodule

// File: rtl/adc3w_master.sv
module adc3w_master
    import adc3w_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sgl_i,
    input  logic              odd_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    input  logic              sdata_i
);

    if (DIV_HALF < 2) begin : g_div_check
        $error("DIV_HALF must be at least 2");
    end

    logic tick;
    logic shift_en;
    logic capture;

    adc3w_halfdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .tick  (tick)
    );

    adc3w_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .sgl      (sgl_i),
        .odd      (odd_i),
        .tick     (tick),
        .cs_n     (cs_n_o),
        .sclk     (sclk_o),
        .sd       (sdata_o),
        .oe       (sdata_oe_o),
        .busy     (busy_o),
        .done     (done_o),
        .shift_en (shift_en),
        .capture  (capture)
    );

    adc3w_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .capture  (capture),
        .sdi      (sdata_i),
        .hi       (hi_o),
        .lo       (lo_o)
    );

endmodule

// File: tb/adc3w_master_test.sv
`timescale 1ns/1ps
module adc3w_master_test;

    localparam int D = 3;
    localparam int FRAME = 27 * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, sgl_i = 1'b0, odd_i = 1'b0;
    logic busy_o, done_o, cs_n_o, sclk_o, sdata_o, sdata_oe_o;
    logic [7:0] hi_o, lo_o;
    logic line;

    // converter model state
    logic r_oe = 1'b0, r_d = 1'b0;
    logic [9:0] r_val = '0;
    logic [3:0] rx_cmd = '0;
    int rise_n = 0, fall_n = 0, cs_falls = 0;
    int cmd_oe_err = 0, rel_err = 0, contention = 0, half_err = 0;
    int run_len = 0;
    logic prev_sclk = 1'b0;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    assign line = sdata_oe_o ? sdata_o : (r_oe ? r_d : 1'b1);

    adc3w_master #(.DIV_HALF(D)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sgl_i(sgl_i), .odd_i(odd_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
        .sdata_oe_o(sdata_oe_o), .sdata_i(line)
    );

    always @(negedge cs_n_o) begin
        rise_n = 0; fall_n = 0; rx_cmd = '0; cs_falls++;
    end
    always @(posedge cs_n_o) r_oe = 1'b0;

    always @(posedge sclk_o) if (!cs_n_o) begin
        rise_n++;
        if (rise_n <= 4) begin
            rx_cmd = {rx_cmd[2:0], line};
            if (!sdata_oe_o) cmd_oe_err++;
        end
    end

    always @(negedge sclk_o) if (!cs_n_o) begin
        fall_n++;
        if (fall_n == 4 && sdata_oe_o) rel_err++;
        if (fall_n >= 4 && fall_n <= 13) begin
            r_oe = 1'b1;
            r_d  = r_val[13 - fall_n];
        end
    end

    always @(negedge clk) begin
        if (sdata_oe_o && r_oe) contention++;
        if (busy_o && fall_n >= 4 && sdata_oe_o) rel_err++;
        if (!busy_o) begin
            run_len = 0; prev_sclk = sclk_o;
        end else if (sclk_o != prev_sclk) begin
            if (run_len != D) half_err++;
            run_len = 1; prev_sclk = sclk_o;
        end else begin
            run_len++;
        end
    end

    function automatic logic [7:0] exp_hi(input logic [9:0] v);
        return v[9:2];
    endfunction
    function automatic logic [7:0] exp_lo(input logic [9:0] v);
        return {v[1:0], 6'b000000};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic run_txn(input logic sgl, input logic odd,
                           input logic [9:0] val, input bit poke);
        int busy_cnt = 0;
        int guard = 0;
        r_val = val;
        cmd_oe_err = 0; rel_err = 0; contention = 0; half_err = 0; cs_falls = 0;
        @(negedge clk);
        start_i = 1'b1; sgl_i = sgl; odd_i = odd;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && guard < 1000) begin
            if (busy_o) busy_cnt++;
            if (poke && busy_cnt == 5) begin
                start_i = 1'b1; sgl_i = ~sgl; odd_i = ~odd;
            end else begin
                start_i = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(busy_cnt == FRAME, "R2", "busy length", busy_cnt, FRAME);
        chk(done_o && !busy_o, "R2", "done with busy low", {done_o, busy_o}, 2'b10);
        chk(hi_o == exp_hi(val), "R6", "high byte", hi_o, exp_hi(val));
        chk(lo_o == exp_lo(val), "R7", "low byte", lo_o, exp_lo(val));
        chk(rx_cmd == {1'b1, sgl, odd, 1'b0}, "R4", "command", rx_cmd, {1'b1, sgl, odd, 1'b0});
        chk(rise_n == 13, "R3", "rising edges", rise_n, 13);
        chk(half_err == 0, "R3", "half-period errors", half_err, 0);
        chk(cmd_oe_err == 0 && rel_err == 0, "R5", "drive window errors",
            cmd_oe_err + rel_err, 0);
        chk(contention == 0, "R5", "contention cycles", contention, 0);
        chk(cs_n_o && !sclk_o, "R8", "cs/sclk at done", {cs_n_o, sclk_o}, 2'b10);
        chk(cs_falls == 1, "R2", "chip-select frames", cs_falls, 1);
        @(negedge clk);
        chk(!done_o, "R2", "done one cycle", done_o, 0);
        chk(hi_o == exp_hi(val) && lo_o == exp_lo(val), "R7", "bytes held",
            {hi_o, lo_o}, {exp_hi(val), exp_lo(val)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n_o && !sclk_o && !sdata_oe_o && !busy_o && !done_o, "R1",
            "idle pins", {cs_n_o, sclk_o, sdata_oe_o, busy_o, done_o}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hi_o == 8'h00 && lo_o == 8'h00, "R1", "reset bytes", {hi_o, lo_o}, 0);
        chk(cs_n_o && !sclk_o && !sdata_oe_o && !busy_o, "R1", "idle after reset",
            {cs_n_o, sclk_o, sdata_oe_o, busy_o}, 4'b1000);

        // directed patterns: R6 R7 corner values
        run_txn(1'b1, 1'b0, 10'h3FF, 1'b0);
        run_txn(1'b0, 1'b1, 10'h000, 1'b0);
        run_txn(1'b1, 1'b1, 10'h200, 1'b0);
        run_txn(1'b0, 1'b0, 10'h001, 1'b0);
        run_txn(1'b1, 1'b0, 10'h2AA, 1'b0);
        // R2: start while busy is ignored
        run_txn(1'b1, 1'b0, 10'h155, 1'b1);

        // R9: reset in the middle of a frame
        r_val = 10'h3C3;
        @(negedge clk);
        start_i = 1'b1; sgl_i = 1'b0; odd_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(cs_n_o && !sclk_o && !sdata_oe_o && !busy_o, "R9", "pins after mid reset",
            {cs_n_o, sclk_o, sdata_oe_o, busy_o}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        run_txn(1'b1, 1'b1, 10'h0F0, 1'b0);

        // random stimulus
        for (int i = 0; i < 20; i++) begin
            run_txn(1'($urandom), 1'($urandom), 10'($urandom), 1'($urandom % 4 == 0));
        end

        summary();
        $finish;
    end

endmodule